// File: doc/BRIEF.md
# Signed Integer Width Converter

This block converts an integer operand among three widths (8, 16 and 32 bits) under control of an 8-bit opcode. The source sits right-aligned in a 32-bit input. The block returns the value at the destination width in a 32-bit result. A widening conversion copies the source sign into the new upper bits. A narrowing conversion keeps only the low bits and reports an overflow when the kept value no longer represents the source.

Three zero-filling moves widen an unsigned operand. The condition flags are computed at the destination width: N is negative, Z is zero, V is overflow and C is carry. Results and flags are registered and appear one cycle after the request with a valid strobe. An opcode outside the supported set raises an error strobe and leaves the previous result and flags untouched.

Top module: `int_width_conv`

## Requirements
- R1: Opcode 0x99 widens byte to word, 0x98 widens byte to longword and 0x32 widens word to longword, each filling the new upper bits with the source's sign bit.
- R2: Opcode 0x33 narrows word to byte, 0xF6 narrows longword to byte and 0xF7 narrows longword to word, each keeping only the low destination-width bits.
- R3: flag_v_o is 1 after a narrowing conversion whose removed source bits are not all equal to the sign bit of the destination value, and is 0 otherwise, which includes every widening conversion.
- R4: flag_n_o equals the destination value's most significant bit, flag_z_o is 1 exactly when the destination value is zero, and flag_c_o is 0 after every accepted conversion.
- R5: Bits of result_o above the destination width are 0, and bits of src_i above the source width have no effect on any output.
- R6: Opcodes 0x9B (byte to word), 0x9A (byte to longword) and 0x3C (word to longword) zero-fill the upper bits, with flag_n_o and flag_v_o both 0.
- R7: Any other opcode, including the unused same-width pairs, pulses err_o together with valid_o and leaves result_o and the four flags unchanged; a following supported opcode leaves err_o at 0.
- R8: valid_o is 1 in the cycle after a clock edge that sampled valid_i high and 0 otherwise; while valid_i is low, result_o and the flags hold even when opcode_i and src_i change.
- R9: Following reset, result_o, all flags, valid_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Conversion selector |
| src_i | input | 32 | Source operand, right-aligned |
| result_o | output | 32 | Converted value, zero above destination width |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag, cleared |
| valid_o | output | 1 | Result strobe |
| err_o | output | 1 | Unsupported opcode strobe |

## Verification
The bench uses the default ZEXT_EN=1, so all nine supported opcodes and the unsupported codes can be decoded. That setting lets the tests reach the zero-fill moves and show that they differ from the sign-filling codes on operands with the top bit set. The vectors also cover operands at the overflow edge, such as 0x80 from a word and 0x8000 from a longword, where V turns on. Garbage placed above the source width checks that those bits are ignored.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LONG_W = 32;
  localparam int DATA_W = LONG_W;
  localparam int OP_W   = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam logic [OP_W-1:0] OP_SX_BW = 8'h99;
  localparam logic [OP_W-1:0] OP_SX_BL = 8'h98;
  localparam logic [OP_W-1:0] OP_SX_WL = 8'h32;
  localparam logic [OP_W-1:0] OP_TR_WB = 8'h33;
  localparam logic [OP_W-1:0] OP_TR_LB = 8'hF6;
  localparam logic [OP_W-1:0] OP_TR_LW = 8'hF7;
  localparam logic [OP_W-1:0] OP_ZX_BW = 8'h9B;
  localparam logic [OP_W-1:0] OP_ZX_BL = 8'h9A;
  localparam logic [OP_W-1:0] OP_ZX_WL = 8'h3C;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2} sz_e;

  typedef struct packed {
    logic ok;
    logic zext;
    sz_e  src_sz;
    sz_e  dst_sz;
  } dec_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic [IDX_W-1:0] msb_of(sz_e s);
    case (s)
      SZ_B:    return IDX_W'(BYTE_W - 1);
      SZ_W:    return IDX_W'(WORD_W - 1);
      default: return IDX_W'(LONG_W - 1);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] mask_of(sz_e s);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) m[i] = (i <= int'(msb_of(s)));
    return m;
  endfunction
endpackage

// File: rtl/conv_decode.sv
module conv_decode
  import conv_pkg::*;
#(
  parameter bit ZEXT_EN = 1'b1
) (
  input  logic [OP_W-1:0] opcode_i,
  output dec_t            dec_o
);
  dec_t sx_dec, zx_dec;

  always_comb begin
    sx_dec = '{ok: 1'b1, zext: 1'b0, src_sz: SZ_B, dst_sz: SZ_B};
    case (opcode_i)
      OP_SX_BW: begin sx_dec.src_sz = SZ_B; sx_dec.dst_sz = SZ_W; end
      OP_SX_BL: begin sx_dec.src_sz = SZ_B; sx_dec.dst_sz = SZ_L; end
      OP_SX_WL: begin sx_dec.src_sz = SZ_W; sx_dec.dst_sz = SZ_L; end
      OP_TR_WB: begin sx_dec.src_sz = SZ_W; sx_dec.dst_sz = SZ_B; end
      OP_TR_LB: begin sx_dec.src_sz = SZ_L; sx_dec.dst_sz = SZ_B; end
      OP_TR_LW: begin sx_dec.src_sz = SZ_L; sx_dec.dst_sz = SZ_W; end
      default:  sx_dec.ok = 1'b0;
    endcase
  end

  generate
    if (ZEXT_EN) begin : g_zext
      always_comb begin
        zx_dec = '{ok: 1'b1, zext: 1'b1, src_sz: SZ_B, dst_sz: SZ_W};
        case (opcode_i)
          OP_ZX_BW: begin zx_dec.src_sz = SZ_B; zx_dec.dst_sz = SZ_W; end
          OP_ZX_BL: begin zx_dec.src_sz = SZ_B; zx_dec.dst_sz = SZ_L; end
          OP_ZX_WL: begin zx_dec.src_sz = SZ_W; zx_dec.dst_sz = SZ_L; end
          default:  zx_dec.ok = 1'b0;
        endcase
      end
    end else begin : g_no_zext
      assign zx_dec = '{ok: 1'b0, zext: 1'b0, src_sz: SZ_B, dst_sz: SZ_B};
    end
  endgenerate

  assign dec_o = sx_dec.ok ? sx_dec : zx_dec;
endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_pkg::*;
(
  input  logic [DATA_W-1:0] src_i,
  input  dec_t              dec_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  logic [DATA_W-1:0] src_mask, dst_mask, ext, upper;
  logic              src_sign, fill, dst_sign;

  always_comb begin
    src_mask = mask_of(dec_i.src_sz);
    dst_mask = mask_of(dec_i.dst_sz);
    src_sign = src_i[msb_of(dec_i.src_sz)];
    fill     = src_sign & ~dec_i.zext;
    // source at its width, extended to full data width
    ext      = (src_i & src_mask) | (fill ? ~src_mask : '0);
    res_o    = ext & dst_mask;
    dst_sign = ext[msb_of(dec_i.dst_sz)];
    upper    = ext & ~dst_mask;
    flags_o.n = dst_sign;
    flags_o.z = (res_o == '0);
    // removed bits must all match the destination sign
    flags_o.v = (upper != (dst_sign ? ~dst_mask : '0));
    flags_o.c = 1'b0;
  end
endmodule

// File: rtl/int_width_conv.sv
module int_width_conv
  import conv_pkg::*;
#(
  parameter bit ZEXT_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [7:0]  opcode_i,
  input  logic [31:0] src_i,
  output logic [31:0] result_o,
  output logic        flag_n_o,
  output logic        flag_z_o,
  output logic        flag_v_o,
  output logic        flag_c_o,
  output logic        valid_o,
  output logic        err_o
);
  dec_t              dec;
  logic [DATA_W-1:0] res_d, res_q;
  flags_t            flags_d, flags_q;
  logic              valid_q, err_q;

  conv_decode #(.ZEXT_EN(ZEXT_EN)) u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  conv_datapath u_dp (
    .src_i   (src_i),
    .dec_i   (dec),
    .res_o   (res_d),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      err_q   <= valid_i & ~dec.ok;
      if (valid_i && dec.ok) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign result_o = res_q;
  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
  assign flag_c_o = flags_q.c;
  assign valid_o  = valid_q;
  assign err_o    = err_q;

  // R3
  widen_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.ok && (dec.dst_sz >= dec.src_sz) |=> !flag_v_o);

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.ok && (dec.dst_sz == SZ_B) |=> (result_o[31:8] == '0));

  // R6
  zext_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dec.ok && dec.zext |=> !flag_n_o && !flag_v_o);

  // R7
  bad_op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !dec.ok |=> err_o && $stable(result_o) &&
      $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o}));

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !err_o && $stable(result_o));
endmodule

// File: tb/sim_int_width_conv.sv
module sim_int_width_conv;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] result_o;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o, valid_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  int_width_conv u0 (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .src_i, .result_o,
    .flag_n_o, .flag_z_o, .flag_v_o, .flag_c_o, .valid_o, .err_o
  );

  // {opcode, src, expected result, expected nzvc}
  localparam int NV = 20;
  localparam logic [75:0] VEC [NV] = '{
    {8'h99, 32'h0000_0005, 32'h0000_0005, 4'b0000},
    {8'h99, 32'h0000_0080, 32'h0000_FF80, 4'b1000},
    {8'h98, 32'h0000_00FF, 32'hFFFF_FFFF, 4'b1000},
    {8'h98, 32'hABCD_0012, 32'h0000_0012, 4'b0000},
    {8'h32, 32'h0000_8000, 32'hFFFF_8000, 4'b1000},
    {8'h32, 32'h0000_0000, 32'h0000_0000, 4'b0100},
    {8'h33, 32'h0000_007F, 32'h0000_007F, 4'b0000},
    {8'h33, 32'h0000_0080, 32'h0000_0080, 4'b1010},
    {8'h33, 32'h0000_FF80, 32'h0000_0080, 4'b1000},
    {8'h33, 32'h0000_0100, 32'h0000_0000, 4'b0110},
    {8'hF6, 32'hFFFF_FF80, 32'h0000_0080, 4'b1000},
    {8'hF6, 32'h1234_5678, 32'h0000_0078, 4'b0010},
    {8'hF7, 32'h0000_7FFF, 32'h0000_7FFF, 4'b0000},
    {8'hF7, 32'h0000_8000, 32'h0000_8000, 4'b1010},
    {8'hF7, 32'hFFFF_0000, 32'h0000_0000, 4'b0110},
    {8'h9B, 32'h0000_00F0, 32'h0000_00F0, 4'b0000},
    {8'h9A, 32'hFFFF_FF80, 32'h0000_0080, 4'b0000},
    {8'h3C, 32'h0000_FFFF, 32'h0000_FFFF, 4'b0000},
    {8'h3C, 32'h0000_0000, 32'h0000_0000, 4'b0100},
    {8'hF6, 32'hFFFF_FFFF, 32'h0000_00FF, 4'b1000}
  };

  function automatic string tag_of(logic [7:0] op);
    case (op)
      8'h99, 8'h98, 8'h32: return "R1";
      8'h33, 8'hF6, 8'hF7: return "R2";
      default:             return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge (one register)
  task automatic apply(logic [7:0] op, logic [31:0] s);
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = op; src_i = s;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic logic [3:0] flags();
    return {flag_n_o, flag_z_o, flag_v_o, flag_c_o};
  endfunction

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r_prev;
    logic [3:0]  f_prev;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9", result_o, 32'h0);
    chk("R9", {28'h0, flags()}, 32'h0);
    chk("R9", {30'h0, valid_o, err_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  op;
      logic [31:0] s, er;
      logic [3:0]  ef;
      {op, s, er, ef} = VEC[i];
      apply(op, s);
      chk(tag_of(op), result_o, er);
      chk("R3/R4", {28'h0, flags()}, {28'h0, ef});
      chk("R8", {31'h0, valid_o}, 32'h1);
    end

    // R5: garbage above word source, byte destination upper bits zero
    apply(8'h33, 32'hDEAD_FF7F);
    chk("R5", result_o, 32'h0000_007F);
    chk("R3", {31'h0, flag_v_o}, 32'h1);

    // R8: idle cycle holds result, valid_o low, inputs changing
    r_prev = result_o;
    @(negedge clk_i);
    opcode_i = 8'h98; src_i = 32'h0000_0080;
    @(negedge clk_i);
    chk("R8", {31'h0, valid_o}, 32'h0);
    chk("R8", result_o, r_prev);

    // R7: unsupported opcodes hold result and flags
    apply(8'hF6, 32'h0000_0080);
    r_prev = result_o; f_prev = flags();
    apply(8'h55, 32'h0000_1234);
    chk("R7", {30'h0, valid_o, err_o}, 32'h3);
    chk("R7", result_o, r_prev);
    chk("R7", {28'h0, flags()}, {28'h0, f_prev});
    apply(8'h00, 32'hFFFF_FFFF);
    chk("R7", {31'h0, err_o}, 32'h1);
    chk("R7", result_o, r_prev);
    apply(8'h99, 32'h0000_0001);
    chk("R7", {31'h0, err_o}, 32'h0);
    chk("R7", result_o, 32'h0000_0001);

    // R4: carry stays cleared after a narrowing overflow
    apply(8'hF7, 32'h8000_0000);
    chk("R4", {28'h0, flags()}, 32'h6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule